// File: doc/BRIEF.md
# Quarter-Wave Sine Tone Synthesizer

This block is a direct digital synthesizer that produces an audio-range sine tone as a stream of 8-bit samples for an external unipolar resistor-ladder converter. A 26-bit phase register advances by a programmable increment on every clock. The tone frequency is therefore `increment x f_clk / 2^26`, and the frequency step is `f_clk / 2^26`: about 0.745 Hz at a 50 MHz clock. An increment of 591 gives about 440 Hz and 1181 gives about 880 Hz.

The lookup table holds only the first quarter of a sine period. The two top phase bits name the quadrant. In the second and fourth quadrants the table address is mirrored. In the lower half-wave the magnitude is subtracted from midscale instead of added, so one small table covers the whole period. A mute control forces the output bus to zero while the phase keeps running. A new increment takes effect without disturbing the phase, so retuning is glitch-free.

Top module: `qw_dds_tone`

## Requirements
- R1: On each active clock edge the phase register adds `phase_inc` to itself, modulo 2^26.
- R2: A change of `phase_inc` is used from the next clock edge onward, and the accumulated phase is not reset.
- R3: Phase bits [25:24] select the quadrant and bits [23:18] form a 6-bit table address. The address is bit-inverted when bit 24 is 1, so for k in 0..63 the sample at table step 64+k equals the sample at step 63-k.
- R4: When phase bit 25 is 0 the sample is 128 plus the magnitude. When bit 25 is 1 it is 128 minus the magnitude. The sample at step 128+k therefore equals 256 minus the sample at step k. The sum saturates at 255.
- R5: While `tone_en` is low the sample bus is 0 one edge later, and the phase keeps advancing.
- R6: While enabled, the sample for phase p is within 1 LSB of 128 + round(127·sin(2π·(p[25:18]+0.5)/256)). It is never below 1.
- R7: While `rst_n` is low the phase and the sample are 0. After `rst_n` rises, the second clock edge is the last one that holds reset, and the first update uses phase 0.
- R8: The sample registered at an edge reflects the phase and `tone_en` present just before that edge, which gives one cycle of latency.
- R9: With an increment of 0 the sample stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tone_en | input | 1 | High to play the tone; low mutes the output to 0 |
| phase_inc | input | 26 | Phase step added each clock; sets the tone frequency |
| sample | output | 8 | Offset-binary sine sample, midscale 128 |

## Verification
The bench steps the increment by exactly one table entry per clock, so every quadrant address is visited in turn. It then compares mirrored and negated samples exactly. A wrong address fold shows up as a reversed or shifted second quadrant, and a wrong sign shows up as a lower half-wave that fails to equal 256 minus the upper one. A bench-side phase model runs through muting, retuning and wrap-around. A design that resets the phase on mute or on retune, or that adds a cycle of latency, drifts away from the model and fails the next samples. Separate runs with a zero increment and with a reset release check that the output holds steady and that the first sample comes from phase 0.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int DEF_PHASE_W = 26;
  localparam int DEF_ADDR_W  = 6;
  localparam int DEF_SAMP_W  = 8;

  // Quarter-wave magnitude at the centre of slot idx, rational sine approximation.
  // Angle unit: half a period equals 4*2^addr_w, slot centre at 2*idx+1.
  function automatic int quarter_mag(int idx, int addr_w, int amp);
    longint p, u, x, d;
    p = 64'(4) << addr_w;
    u = 2 * longint'(idx) + 1;
    x = u * (p - u);
    d = 5 * p * p - 4 * x;
    return int'((2 * 16 * longint'(amp) * x + d) / (2 * d));
  endfunction
endpackage

// File: rtl/dds_rst_sync.sv
module dds_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = dds_pkg::DEF_PHASE_W,
  parameter int TOP_W   = dds_pkg::DEF_ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] inc,
  output logic [TOP_W-1:0]   phase_top
);
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               live_q;

  always_comb begin
    phase_d = phase_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      live_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      live_q  <= 1'b1;
    end
  end

  assign phase_top = phase_q[PHASE_W-1 -: TOP_W];

  // R1: phase grows by the increment seen at the previous edge, wrapping naturally
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> (phase_q == PHASE_W'($past(phase_q) + $past(inc))));
endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int ADDR_W = dds_pkg::DEF_ADDR_W,
  parameter int MAG_W  = dds_pkg::DEF_SAMP_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP   = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign tbl[g] = MAG_W'(dds_pkg::quarter_mag(g, ADDR_W, AMP));
  end

  assign mag = tbl[addr];
endmodule

// File: rtl/dds_fold.sv
module dds_fold #(
  parameter int ADDR_W = dds_pkg::DEF_ADDR_W,
  parameter int SAMP_W = dds_pkg::DEF_SAMP_W
) (
  input  logic [ADDR_W+1:0] phase_top,
  output logic [SAMP_W-1:0] value
);
  localparam int MAG_W = SAMP_W - 1;
  localparam logic [SAMP_W:0] MID = (SAMP_W+1)'(1) << (SAMP_W - 1);
  localparam logic [SAMP_W:0] TOP = (SAMP_W+1)'((1 << SAMP_W) - 1);

  logic              lower_half, mirror;
  logic [ADDR_W-1:0] raw_addr, rom_addr;
  logic [MAG_W-1:0]  mag;
  logic [SAMP_W:0]   wide;

  assign lower_half = phase_top[ADDR_W+1];
  assign mirror     = phase_top[ADDR_W];
  assign raw_addr   = phase_top[ADDR_W-1:0];

  always_comb begin
    rom_addr = mirror ? ~raw_addr : raw_addr;
  end

  dds_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .addr (rom_addr),
    .mag  (mag)
  );

  always_comb begin
    if (lower_half) wide = MID - (SAMP_W+1)'(mag);
    else            wide = MID + (SAMP_W+1)'(mag);
    if (wide > TOP) value = TOP[SAMP_W-1:0];
    else            value = wide[SAMP_W-1:0];
  end
endmodule

// File: rtl/qw_dds_tone.sv
module qw_dds_tone #(
  parameter int PHASE_W = dds_pkg::DEF_PHASE_W,
  parameter int ADDR_W  = dds_pkg::DEF_ADDR_W,
  parameter int SAMP_W  = dds_pkg::DEF_SAMP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tone_en,
  input  logic [PHASE_W-1:0] phase_inc,
  output logic [SAMP_W-1:0]  sample
);
  localparam int TOP_W = ADDR_W + 2;

  logic              rst_sync_n;
  logic [TOP_W-1:0]  phase_top;
  logic [SAMP_W-1:0] folded, sample_d, sample_q;

  dds_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W), .TOP_W(TOP_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inc       (phase_inc),
    .phase_top (phase_top)
  );

  dds_fold #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_fold (
    .phase_top (phase_top),
    .value     (folded)
  );

  always_comb begin
    sample_d = tone_en ? folded : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sample_q <= '0;
    else             sample_q <= sample_d;
  end

  assign sample = sample_q;

  // R5: muted input gives an all-zero sample one edge later
  p_mute_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tone_en |=> (sample == '0));

  // R6: an enabled sample never drops to zero
  p_enabled_floor_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tone_en |=> (sample != '0));

  // R4: upper half-wave lands at or above midscale
  p_upper_sign_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tone_en && !phase_top[TOP_W-1]) |=> sample[SAMP_W-1]);

  // R4: lower half-wave lands below midscale
  p_lower_sign_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tone_en && phase_top[TOP_W-1]) |=> !sample[SAMP_W-1]);
endmodule

// File: tb/sim_qw_dds_tone.sv
module sim_qw_dds_tone;
  logic        clk;
  logic        rst_n;
  logic        tone_en;
  logic [25:0] phase_inc;
  logic [7:0]  sample;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [25:0] ph_m;
  int hist [256];
  int hist_n;

  qw_dds_tone u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tone_en   (tone_en),
    .phase_inc (phase_inc),
    .sample    (sample)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ref_sample(logic [25:0] ph);
    int  idx;
    real a;
    idx = int'(ph[25:18]);
    a   = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / 256.0;
    return 128 + int'(127.0 * $sin(a));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Step n cycles against the phase model; inputs stay fixed during the run.
  task automatic run(int n, string req);
    for (int k = 0; k < n; k++) begin
      int  exp;
      bit  en_now;
      @(posedge clk);
      en_now = tone_en;
      exp    = en_now ? ref_sample(ph_m) : 0;
      ph_m   = ph_m + phase_inc;
      @(negedge clk);
      if (en_now) begin
        check((int'(sample) >= exp - 1) && (int'(sample) <= exp + 1), req, int'(sample), exp);
        if (hist_n < 256) begin
          hist[hist_n] = int'(sample);
          hist_n++;
        end
      end else begin
        check(sample == 8'd0, req, int'(sample), 0);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tone_en = 1'b1; phase_inc = 26'd1 << 18;
    repeat (3) @(negedge clk);
    check(sample == 8'd0, "R7 reset", int'(sample), 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(sample == 8'd0, "R7 release", int'(sample), 0);
    ph_m = '0; hist_n = 0;
  endtask

  task automatic t_sweep;
    run(256, "R6/R8 sweep");
    for (int k = 0; k < 64; k++)
      check(hist[64+k] == hist[63-k], "R3 mirror", hist[64+k], hist[63-k]);
    for (int k = 0; k < 128; k++)
      check(hist[128+k] == 256 - hist[k], "R4 negate", hist[128+k], 256 - hist[k]);
    check(hist[0] >= 1 && hist[191] >= 1, "R6 floor", hist[191], 1);
  endtask

  task automatic t_note;
    phase_inc = 26'd591;
    run(3000, "R1 note 440");
  endtask

  task automatic t_mute;
    tone_en = 1'b0;
    run(40, "R5 mute");
    tone_en = 1'b1;
    run(40, "R5 resume phase");
  endtask

  task automatic t_retune;
    phase_inc = 26'h0049D;
    run(300, "R2 retune up");
    phase_inc = 26'd300000;
    run(300, "R2 retune jump");
  endtask

  task automatic t_wrap;
    phase_inc = (26'd1 << 25) + 26'd262149;
    run(100, "R1 wrap");
  endtask

  task automatic t_hold;
    int first;
    phase_inc = 26'd0;
    run(1, "R9 hold");
    first = int'(sample);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(int'(sample) == first, "R9 hold", int'(sample), first);
    end
    ph_m = ph_m;
  endtask

  initial begin
    t_reset;
    t_sweep;
    t_note;
    t_mute;
    t_retune;
    t_wrap;
    t_hold;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule